// File: doc/BRIEF.md
# Patrol Scrub Address Engine

This block produces background scrub requests that sweep every rank address of memory, one request per programmed interval. A cursor steps through the rank address range, then on to the next rank, then the next channel. When it passes the last channel it wraps back to the range start and records that a full pass is done. Software sets the modes with plain level inputs: run, halt at the end of a pass, halt on an error, and single shot. It can load the cursor and launch a scrub on demand with a kick pulse.

Requests leave on a valid/ready stream. The engine raises `req_valid` with the cursor as payload. It keeps valid and payload steady until `req_ready` is seen high on a clock edge, and it never withdraws a request. The interval is counted from the edge that accepts a request, so a consumer that stalls delays every later request.

Scrub results come back as one-cycle `rsp_valid` pulses that flag poison or an uncorrectable error. The engine reports errors that need logging and asks for poison write-back when conversion is enabled. It can also halt on an error. Two sticky halt flags stop the sweep. Clearing a flag, or dropping the mode that set it, lets the sweep resume.

Top module: `patrol_scrub_engine`

## Requirements
- R1: After reset, `req_valid`, `log_valid`, `poison_wb`, `issued`, `pass_done`, `cmpl_halt`, `err_halt` and `start_pend` are all 0.
- R2: While `req_valid` is 1 and `req_ready` is 0, the next cycle still has `req_valid` at 1 with the same `req_addr`, `req_rank` and `req_chan`.
- R3: The engine runs when (`scrub_en` or `start_pend`) is 1 and no halt is active (`cmpl_halt`, `err_halt`, or a completed single shot). An interval counter reloads with `interval` on each accepted request. It counts down by one per cycle only while the engine runs with no request pending, and it is held otherwise. A kick zeroes it. `req_valid` rises on the edge after a cycle in which the engine runs, the counter is 0 and no request is pending.
- R4: Each accepted request (not in single shot) advances the cursor. The address steps by one. At or beyond `range_hi` it returns to `range_lo` and the rank steps. At or beyond `rank_max` the rank returns to 0 and the channel steps. At or beyond `chan_max` the channel returns to 0, which is a wrap.
- R5: A wrap sets the sticky `pass_done`. A `pass_done_clr` pulse clears it, with a same-cycle wrap taking priority. `pass_done` never stops the sweep.
- R6: A wrap while `halt_at_end` is 1 sets `cmpl_halt`, and no new request is raised while it is set. It clears on `cmpl_halt_clr`, or when `halt_at_end` is 0. The sweep then restarts at (`range_lo`, rank 0, channel 0).
- R7: A response with poison or uncorrectable set while `halt_on_err` is 1 sets `err_halt`, and no new request is raised while it is set. It clears on `err_halt_clr`, or when `halt_on_err` is 0. The sweep then resumes at the address after the last one issued.
- R8: One cycle after a response, `log_valid` pulses if the response was poison, or uncorrectable with `to_poison_en` at 1. `poison_wb` pulses only for uncorrectable with `to_poison_en` at 1.
- R9: With `single_shot` at 1, an accepted request leaves the cursor unchanged and halts the engine. The halt ends when `single_shot` is 0 or on a kick.
- R10: A `kick` pulse sets `start_pend`, which lets the engine issue from the cursor even with `scrub_en` at 0. `start_pend` clears on the next accepted request unless a kick arrives in the same cycle.
- R11: On each accepted request, `last_addr`, `last_rank` and `last_chan` take the request payload, and `issued` becomes 1 and stays 1.
- R12: A `sw_wr` pulse loads the cursor from `sw_addr`, `sw_rank` and `sw_chan` when no request is pending. It is ignored while `req_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scrub_en | input | 1 | Run the periodic sweep |
| halt_at_end | input | 1 | Halt when a pass wraps |
| halt_on_err | input | 1 | Halt on an error response |
| single_shot | input | 1 | Issue the cursor once and halt |
| to_poison_en | input | 1 | Turn uncorrectable results into poison |
| interval | input | INTV_W | Cycles between requests |
| range_lo | input | ADDR_W | First rank address of the range |
| range_hi | input | ADDR_W | Last rank address of the range |
| rank_max | input | RANK_W | Highest rank swept |
| chan_max | input | CHAN_W | Highest channel swept |
| sw_wr | input | 1 | Load the cursor |
| sw_addr | input | ADDR_W | Cursor address to load |
| sw_rank | input | RANK_W | Cursor rank to load |
| sw_chan | input | CHAN_W | Cursor channel to load |
| kick | input | 1 | Launch a scrub from the cursor |
| cmpl_halt_clr | input | 1 | Clear the end-of-pass halt |
| err_halt_clr | input | 1 | Clear the error halt |
| pass_done_clr | input | 1 | Clear the pass-done flag |
| req_valid | output | 1 | Scrub request valid |
| req_ready | input | 1 | Consumer accepts the request |
| req_addr | output | ADDR_W | Request rank address |
| req_rank | output | RANK_W | Request rank |
| req_chan | output | CHAN_W | Request channel |
| rsp_valid | input | 1 | Scrub result strobe |
| rsp_poison | input | 1 | Result was poison |
| rsp_uncorr | input | 1 | Result was uncorrectable |
| log_valid | output | 1 | Error to be logged |
| poison_wb | output | 1 | Poison write-back request |
| last_addr | output | ADDR_W | Last issued address |
| last_rank | output | RANK_W | Last issued rank |
| last_chan | output | CHAN_W | Last issued channel |
| issued | output | 1 | At least one request accepted |
| pass_done | output | 1 | Sticky full-pass flag |
| cmpl_halt | output | 1 | Halted at end of pass |
| err_halt | output | 1 | Halted on error |
| start_pend | output | 1 | Kick not yet issued |

## Verification
The bench keeps the default address, rank and channel widths. It builds the block with a 12-bit interval counter, programs an interval of 3 and limits the sweep to addresses 5 to 7, ranks 0 to 1 and channels 0 to 1. A full pass is then twelve requests. This brings several wraps, both halts with their resume points, single shot and kick into a few hundred cycles. Ready is pulsed in a pattern so that long back-pressure stalls fall between accepted requests.

// File: rtl/ps_pkg.sv
package ps_pkg;
  localparam int DEF_ADDR_W = 31;
  localparam int DEF_RANK_W = 4;
  localparam int DEF_CHAN_W = 2;
  localparam int DEF_INTV_W = 24;

  // Which field of the cursor moves on the next accepted request
  typedef enum logic [1:0] {
    STEP_ADDR = 2'd0,
    STEP_RANK = 2'd1,
    STEP_CHAN = 2'd2,
    STEP_WRAP = 2'd3
  } step_e;
endpackage

// File: rtl/ps_interval_timer.sv
module ps_interval_timer #(
  parameter int INTV_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              dec_i,
  input  logic [INTV_W-1:0] interval_i,
  output logic              zero_o
);
  logic [INTV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (load_i)                 cnt_q <= interval_i;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ps_cursor.sv
module ps_cursor
  import ps_pkg::*;
#(
  parameter int ADDR_W = 31,
  parameter int RANK_W = 4,
  parameter int CHAN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [RANK_W-1:0] load_rank_i,
  input  logic [CHAN_W-1:0] load_chan_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic [RANK_W-1:0] rank_max_i,
  input  logic [CHAN_W-1:0] chan_max_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [RANK_W-1:0] rank_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic              wrap_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [RANK_W-1:0] rank_q;
  logic [CHAN_W-1:0] chan_q;
  step_e             step;

  always_comb begin
    if (addr_q < hi_i)          step = STEP_ADDR;
    else if (rank_q < rank_max_i) step = STEP_RANK;
    else if (chan_q < chan_max_i) step = STEP_CHAN;
    else                          step = STEP_WRAP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      rank_q <= '0;
      chan_q <= '0;
    end else if (load_i) begin
      addr_q <= load_addr_i;
      rank_q <= load_rank_i;
      chan_q <= load_chan_i;
    end else if (adv_i) begin
      unique case (step)
        STEP_ADDR: addr_q <= addr_q + 1'b1;
        STEP_RANK: begin
          addr_q <= lo_i;
          rank_q <= rank_q + 1'b1;
        end
        STEP_CHAN: begin
          addr_q <= lo_i;
          rank_q <= '0;
          chan_q <= chan_q + 1'b1;
        end
        default: begin
          addr_q <= lo_i;
          rank_q <= '0;
          chan_q <= '0;
        end
      endcase
    end
  end

  assign addr_o = addr_q;
  assign rank_o = rank_q;
  assign chan_o = chan_q;
  assign wrap_o = adv_i && (step == STEP_WRAP);
endmodule

// File: rtl/patrol_scrub_engine.sv
module patrol_scrub_engine
  import ps_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int RANK_W = DEF_RANK_W,
  parameter int CHAN_W = DEF_CHAN_W,
  parameter int INTV_W = DEF_INTV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scrub_en,
  input  logic              halt_at_end,
  input  logic              halt_on_err,
  input  logic              single_shot,
  input  logic              to_poison_en,
  input  logic [INTV_W-1:0] interval,
  input  logic [ADDR_W-1:0] range_lo,
  input  logic [ADDR_W-1:0] range_hi,
  input  logic [RANK_W-1:0] rank_max,
  input  logic [CHAN_W-1:0] chan_max,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [RANK_W-1:0] sw_rank,
  input  logic [CHAN_W-1:0] sw_chan,
  input  logic              kick,
  input  logic              cmpl_halt_clr,
  input  logic              err_halt_clr,
  input  logic              pass_done_clr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [RANK_W-1:0] req_rank,
  output logic [CHAN_W-1:0] req_chan,
  input  logic              rsp_valid,
  input  logic              rsp_poison,
  input  logic              rsp_uncorr,
  output logic              log_valid,
  output logic              poison_wb,
  output logic [ADDR_W-1:0] last_addr,
  output logic [RANK_W-1:0] last_rank,
  output logic [CHAN_W-1:0] last_chan,
  output logic              issued,
  output logic              pass_done,
  output logic              cmpl_halt,
  output logic              err_halt,
  output logic              start_pend
);
  logic once_done_q;
  logic halted, run, fire, launch, cnt_zero, wrap, rsp_err;

  assign halted  = cmpl_halt | err_halt | once_done_q;
  assign run     = (scrub_en | start_pend) & ~halted;
  assign fire    = req_valid & req_ready;
  assign launch  = run & cnt_zero & ~req_valid;
  assign rsp_err = rsp_valid & (rsp_poison | rsp_uncorr);

  ps_interval_timer #(.INTV_W(INTV_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (kick),
    .load_i     (fire),
    .dec_i      (run & ~req_valid),
    .interval_i (interval),
    .zero_o     (cnt_zero)
  );

  ps_cursor #(.ADDR_W(ADDR_W), .RANK_W(RANK_W), .CHAN_W(CHAN_W)) u_cursor (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (sw_wr & ~req_valid),
    .load_addr_i (sw_addr),
    .load_rank_i (sw_rank),
    .load_chan_i (sw_chan),
    .adv_i       (fire & ~single_shot),
    .lo_i        (range_lo),
    .hi_i        (range_hi),
    .rank_max_i  (rank_max),
    .chan_max_i  (chan_max),
    .addr_o      (req_addr),
    .rank_o      (req_rank),
    .chan_o      (req_chan),
    .wrap_o      (wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid   <= 1'b0;
      once_done_q <= 1'b0;
      start_pend  <= 1'b0;
      pass_done   <= 1'b0;
      cmpl_halt   <= 1'b0;
      err_halt    <= 1'b0;
      log_valid   <= 1'b0;
      poison_wb   <= 1'b0;
      issued      <= 1'b0;
      last_addr   <= '0;
      last_rank   <= '0;
      last_chan   <= '0;
    end else begin
      if (launch)    req_valid <= 1'b1;
      else if (fire) req_valid <= 1'b0;

      if (fire && single_shot)      once_done_q <= 1'b1;
      else if (!single_shot || kick) once_done_q <= 1'b0;

      if (kick)      start_pend <= 1'b1;
      else if (fire) start_pend <= 1'b0;

      if (wrap)               pass_done <= 1'b1;
      else if (pass_done_clr) pass_done <= 1'b0;

      if (wrap && halt_at_end)                cmpl_halt <= 1'b1;
      else if (cmpl_halt_clr || !halt_at_end) cmpl_halt <= 1'b0;

      if (rsp_err && halt_on_err)            err_halt <= 1'b1;
      else if (err_halt_clr || !halt_on_err) err_halt <= 1'b0;

      log_valid <= rsp_valid & (rsp_poison | (rsp_uncorr & to_poison_en));
      poison_wb <= rsp_valid & rsp_uncorr & to_poison_en;

      if (fire) begin
        last_addr <= req_addr;
        last_rank <= req_rank;
        last_chan <= req_chan;
        issued    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ps_checker.sv
module ps_checker #(
  parameter int ADDR_W = 31,
  parameter int RANK_W = 4,
  parameter int CHAN_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              kick,
  input logic              pass_done_clr,
  input logic              rsp_valid,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [RANK_W-1:0] req_rank,
  input logic [CHAN_W-1:0] req_chan,
  input logic              log_valid,
  input logic              poison_wb,
  input logic [ADDR_W-1:0] last_addr,
  input logic [RANK_W-1:0] last_rank,
  input logic [CHAN_W-1:0] last_chan,
  input logic              issued,
  input logic              pass_done,
  input logic              cmpl_halt,
  input logic              err_halt,
  input logic              start_pend
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_rank) && $stable(req_chan)); // R2

  AST_LAST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> issued && last_addr == $past(req_addr) && last_rank == $past(req_rank) && last_chan == $past(req_chan)); // R11

  AST_PASS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done && !pass_done_clr |=> pass_done); // R5

  AST_CMPL_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_halt && !req_valid |=> !req_valid); // R6

  AST_ERR_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    err_halt && !req_valid |=> !req_valid); // R7

  AST_KICK_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !kick |=> !start_pend); // R10

  AST_LOG_FROM_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> $past(rsp_valid)); // R8

  AST_WB_IS_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    poison_wb |-> log_valid); // R8
endmodule

bind patrol_scrub_engine ps_checker #(.ADDR_W(ADDR_W), .RANK_W(RANK_W), .CHAN_W(CHAN_W)) u_ps_checker (
  .clk(clk), .rst_n(rst_n), .kick(kick), .pass_done_clr(pass_done_clr), .rsp_valid(rsp_valid),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_rank(req_rank),
  .req_chan(req_chan), .log_valid(log_valid), .poison_wb(poison_wb), .last_addr(last_addr),
  .last_rank(last_rank), .last_chan(last_chan), .issued(issued), .pass_done(pass_done),
  .cmpl_halt(cmpl_halt), .err_halt(err_halt), .start_pend(start_pend)
);

// File: tb/test_patrol_scrub_engine.sv
module test_patrol_scrub_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 31;
  localparam int RW = 4;
  localparam int CW = 2;
  localparam int IW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scrub_en = 0, halt_at_end = 0, halt_on_err = 0, single_shot = 0, to_poison_en = 0;
  logic [IW-1:0] interval = '0;
  logic [AW-1:0] range_lo = '0, range_hi = '0, sw_addr = '0;
  logic [RW-1:0] rank_max = '0, sw_rank = '0;
  logic [CW-1:0] chan_max = '0, sw_chan = '0;
  logic sw_wr = 0, kick = 0, cmpl_halt_clr = 0, err_halt_clr = 0, pass_done_clr = 0;
  logic req_ready = 0, rsp_valid = 0, rsp_poison = 0, rsp_uncorr = 0;
  logic req_valid, log_valid, poison_wb, issued, pass_done, cmpl_halt, err_halt, start_pend;
  logic [AW-1:0] req_addr, last_addr;
  logic [RW-1:0] req_rank, last_rank;
  logic [CW-1:0] req_chan, last_chan;

  patrol_scrub_engine #(.ADDR_W(AW), .RANK_W(RW), .CHAN_W(CW), .INTV_W(IW)) i_patrol_scrub_engine (
    .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en), .halt_at_end(halt_at_end),
    .halt_on_err(halt_on_err), .single_shot(single_shot), .to_poison_en(to_poison_en),
    .interval(interval), .range_lo(range_lo), .range_hi(range_hi), .rank_max(rank_max),
    .chan_max(chan_max), .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_rank(sw_rank), .sw_chan(sw_chan),
    .kick(kick), .cmpl_halt_clr(cmpl_halt_clr), .err_halt_clr(err_halt_clr),
    .pass_done_clr(pass_done_clr), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_rank(req_rank), .req_chan(req_chan), .rsp_valid(rsp_valid),
    .rsp_poison(rsp_poison), .rsp_uncorr(rsp_uncorr), .log_valid(log_valid),
    .poison_wb(poison_wb), .last_addr(last_addr), .last_rank(last_rank), .last_chan(last_chan),
    .issued(issued), .pass_done(pass_done), .cmpl_halt(cmpl_halt), .err_halt(err_halt),
    .start_pend(start_pend)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  task automatic chk(string tag, longint got, longint exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_valid, m_once, m_start, m_pass, m_cmpl, m_err, m_log, m_pwb, m_issued;
  int m_cnt;
  longint m_addr, m_rank, m_chan, m_laddr, m_lrank, m_lchan;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_once = 0; m_start = 0; m_pass = 0; m_cmpl = 0; m_err = 0;
      m_log = 0; m_pwb = 0; m_issued = 0; m_cnt = 0;
      m_addr = 0; m_rank = 0; m_chan = 0; m_laddr = 0; m_lrank = 0; m_lchan = 0;
    end else begin
      bit go, fire, launch, wrap, halted;
      halted = m_cmpl || m_err || m_once;
      go     = (scrub_en || m_start) && !halted;
      fire   = m_valid && req_ready;
      launch = go && m_cnt == 0 && !m_valid;
      wrap   = 0;
      if (fire) begin
        m_laddr = m_addr; m_lrank = m_rank; m_lchan = m_chan; m_issued = 1;
        if (!single_shot) begin
          if (m_addr < range_hi) m_addr++;
          else begin
            m_addr = range_lo;
            if (m_rank < rank_max) m_rank++;
            else begin
              m_rank = 0;
              if (m_chan < chan_max) m_chan++;
              else begin m_chan = 0; wrap = 1; end
            end
          end
        end
      end else if (sw_wr && !m_valid) begin
        m_addr = sw_addr; m_rank = sw_rank; m_chan = sw_chan;
      end
      if (kick) m_cnt = 0;
      else if (fire) m_cnt = interval;
      else if (go && !m_valid && m_cnt != 0) m_cnt--;
      if (launch) m_valid = 1; else if (fire) m_valid = 0;
      if (fire && single_shot) m_once = 1; else if (!single_shot || kick) m_once = 0;
      if (kick) m_start = 1; else if (fire) m_start = 0;
      if (wrap) m_pass = 1; else if (pass_done_clr) m_pass = 0;
      if (wrap && halt_at_end) m_cmpl = 1; else if (cmpl_halt_clr || !halt_at_end) m_cmpl = 0;
      if (rsp_valid && (rsp_poison || rsp_uncorr) && halt_on_err) m_err = 1;
      else if (err_halt_clr || !halt_on_err) m_err = 0;
      m_log = rsp_valid && (rsp_poison || (rsp_uncorr && to_poison_en));
      m_pwb = rsp_valid && rsp_uncorr && to_poison_en;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 req_valid", req_valid, m_valid);
      if (m_valid) begin
        chk("R4 req_addr", req_addr, m_addr);
        chk("R4 req_rank", req_rank, m_rank);
        chk("R4 req_chan", req_chan, m_chan);
      end
      chk("R11 last_addr", last_addr, m_laddr);
      chk("R11 last_rank", last_rank, m_lrank);
      chk("R11 last_chan", last_chan, m_lchan);
      chk("R11 issued", issued, m_issued);
      chk("R5 pass_done", pass_done, m_pass);
      chk("R6 cmpl_halt", cmpl_halt, m_cmpl);
      chk("R7 err_halt", err_halt, m_err);
      chk("R8 log_valid", log_valid, m_log);
      chk("R8 poison_wb", poison_wb, m_pwb);
      chk("R10 start_pend", start_pend, m_start);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_valid(int limit);
    for (int i = 0; i < limit && !req_valid; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    longint la, lr, lc, ea, er, ec, held;
    step(3);
    // R1 reset state
    chk("R1 req_valid", req_valid, 0);
    chk("R1 pass_done", pass_done, 0);
    chk("R1 cmpl_halt", cmpl_halt, 0);
    chk("R1 err_halt", err_halt, 0);
    chk("R1 issued", issued, 0);
    chk("R1 start_pend", start_pend, 0);
    chk("R1 log_valid", log_valid, 0);
    rst_n = 1;
    range_lo = 5; range_hi = 7; rank_max = 1; chan_max = 1; interval = 3;
    sw_addr = 5; sw_rank = 0; sw_chan = 0; sw_wr = 1; step(1); sw_wr = 0;
    // R4 R5: free-running sweep with ready high
    scrub_en = 1; req_ready = 1;
    step(75);
    chk("R5 pass_done set after full pass", pass_done, 1);
    pass_done_clr = 1; step(1); pass_done_clr = 0; step(1);
    chk("R5 pass_done cleared by pulse", pass_done, 0);
    // R2 back-pressure pattern
    for (int i = 0; i < 60; i++) begin req_ready = (i % 4 == 3); step(1); end
    req_ready = 1;
    // R6 halt at the end of a pass
    halt_at_end = 1;
    for (int i = 0; i < 200 && !cmpl_halt; i++) step(1);
    chk("R6 cmpl_halt set", cmpl_halt, 1);
    step(20);
    chk("R6 no request while halted", req_valid, 0);
    chk("R6 last addr is range end", last_addr, 7);
    chk("R6 last chan is chan_max", last_chan, 1);
    cmpl_halt_clr = 1; step(1); cmpl_halt_clr = 0;
    wait_valid(50);
    chk("R6 restart addr", req_addr, 5);
    chk("R6 restart rank", req_rank, 0);
    chk("R6 restart chan", req_chan, 0);
    halt_at_end = 0;
    // R7 R8 halt on poison
    step(7);
    halt_on_err = 1;
    rsp_valid = 1; rsp_poison = 1; step(1); rsp_valid = 0; rsp_poison = 0;
    chk("R8 poison logged", log_valid, 1);
    chk("R7 err_halt set", err_halt, 1);
    step(15);
    la = last_addr; lr = last_rank; lc = last_chan;
    if (la < 7) begin ea = la + 1; er = lr; ec = lc; end
    else if (lr < 1) begin ea = 5; er = lr + 1; ec = lc; end
    else begin ea = 5; er = 0; ec = (lc < 1) ? lc + 1 : 0; end
    err_halt_clr = 1; step(1); err_halt_clr = 0;
    wait_valid(50);
    chk("R7 resume addr", req_addr, ea);
    chk("R7 resume rank", req_rank, er);
    chk("R7 resume chan", req_chan, ec);
    // R8 uncorrectable with and without conversion
    to_poison_en = 1;
    rsp_valid = 1; rsp_uncorr = 1; step(1); rsp_valid = 0; rsp_uncorr = 0;
    chk("R8 converted log", log_valid, 1);
    chk("R8 poison write-back", poison_wb, 1);
    step(3);
    to_poison_en = 0;
    rsp_valid = 1; rsp_uncorr = 1; step(1); rsp_valid = 0; rsp_uncorr = 0;
    chk("R8 unconverted not logged", log_valid, 0);
    chk("R8 unconverted no write-back", poison_wb, 0);
    chk("R7 uncorr halts", err_halt, 1);
    halt_on_err = 0; step(2);
    chk("R7 dropping mode clears halt", err_halt, 0);
    // R9 R10 single shot launched by kick with scrub_en low
    scrub_en = 0; step(20);
    sw_addr = 6; sw_rank = 1; sw_chan = 0; sw_wr = 1; step(1); sw_wr = 0;
    single_shot = 1;
    kick = 1; step(1); kick = 0;
    chk("R10 start_pend set", start_pend, 1);
    wait_valid(20);
    chk("R10 kick addr", req_addr, 6);
    chk("R10 kick rank", req_rank, 1);
    step(3);
    chk("R10 start_pend cleared", start_pend, 0);
    chk("R9 last addr", last_addr, 6);
    step(20);
    chk("R9 halted after one", req_valid, 0);
    kick = 1; step(1); kick = 0;
    wait_valid(20);
    chk("R9 cursor not advanced", req_addr, 6);
    step(3);
    single_shot = 0;
    // R12 cursor write ignored while pending
    req_ready = 0; scrub_en = 1;
    wait_valid(50);
    held = req_addr;
    sw_addr = 7; sw_rank = 0; sw_chan = 1; sw_wr = 1; step(1); sw_wr = 0;
    step(2);
    chk("R12 write ignored while valid", req_addr, held);
    chk("R2 held under stall", req_valid, 1);
    req_ready = 1; step(30);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule